// File: doc/BRIEF.md
# Parallel-Prefix Tree Adder

This block adds two unsigned operands of a power-of-two width and a carry-in in a single combinational pass. Each bit first reduces to a generate/propagate pair. A tree of identical two-input group cells then turns these pairs into every prefix carry, and the sum bits come from XOR-ing each bit propagate with the carry that arrives at it. The block holds no state and has no pipelining, so the outputs follow the inputs within the same time step.

A compile-time topology parameter chooses how the group cells are wired, and this sets the depth and fanout of the tree. The three choices are:

- 0: each level pairs every node with the node a power-of-two stride below it. This gives log2 N levels and a fanout of at most two.
- 1: a recursive split in which a single node in each block feeds the whole upper half of that block. This gives log2 N levels and a larger fanout.
- 2: a sparse up-sweep followed by a down-sweep that fills in the remaining positions. This gives 2·log2 N − 1 levels and a fanout of at most two.

The carry-in is folded into the bit-0 generate term. The carry-out is the prefix generate that spans all bits. A constant output reports the number of cell levels that were built.

Top module: `pfx_tree_adder`

## Requirements
- R1: `sum_out` equals the low WIDTH bits of `a_in + b_in + c_in` for every topology.
- R2: `c_out` equals bit WIDTH of `a_in + b_in + c_in` for every topology.
- R3: When every bit propagates (`a_in ^ b_in` all ones), `c_in = 1` gives `sum_out = 0` with `c_out = 1`, and `c_in = 0` gives all ones with `c_out = 0`.
- R4: With TOPOLOGY = 0, `tree_levels` equals log2(WIDTH).
- R5: With TOPOLOGY = 1, `tree_levels` equals log2(WIDTH).
- R6: With TOPOLOGY = 2, `tree_levels` equals 2·log2(WIDTH) − 1.
- R7: At WIDTH = 8, all three topologies give the correct sum and carry-out for every operand pair and both carry-in values.
- R8: For each bit i, the internal prefix carry out of bit i equals the carry out of the sum of `a_in[i:0]`, `b_in[i:0]` and `c_in`, and the outputs settle without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum modulo 2^WIDTH |
| c_out | output | 1 | Carry out of the top bit |
| tree_levels | output | 8 | Number of group-cell levels built (constant) |

## Verification
The assertions assume that the operands and the carry-in are fully known. Each check is guarded so that it is skipped while any input bit is X or Z. The bench therefore always drives complete two-state values, sets every input before the first compare, and changes all inputs together before it lets time advance. The carry-per-node check depends on the carry-in being folded into the bit-0 generate, so a node's prefix carry includes the carry-in.

// File: rtl/pfx_adder_pkg.sv
// Package: topology codes and the elaboration-time wiring rules of the prefix tree.
// Assumes the width is a power of two, at least 2.
package pfx_adder_pkg;

    localparam int TOPO_STRIDE = 0;   // every node, doubling stride
    localparam int TOPO_SPLIT  = 1;   // recursive halving, high fanout
    localparam int TOPO_SPARSE = 2;   // up-sweep then down-sweep

    // Number of group-cell levels for a topology over 2**lg bits
    function automatic int tree_depth(input int topo, input int lg);
        if (topo == TOPO_SPARSE) return 2 * lg - 1;
        return lg;
    endfunction

    // Lower partner node of node i at level lvl, or -1 when node i passes through
    function automatic int pair_index(input int topo, input int lg, input int lvl, input int i);
        int s;
        int d;
        if (topo == TOPO_STRIDE) begin
            if (i >= (1 << lvl)) return i - (1 << lvl);
            return -1;
        end
        if (topo == TOPO_SPLIT) begin
            if (((i >> lvl) & 1) == 1)
                return ((i >> (lvl + 1)) << (lvl + 1)) + (1 << lvl) - 1;
            return -1;
        end
        if (lvl < lg) begin
            if (((i + 1) % (1 << (lvl + 1))) == 0) return i - (1 << lvl);
            return -1;
        end
        d = lvl - lg;
        s = 1 << (lg - 2 - d);
        if ((((i + 1) % (2 * s)) == s) && (i >= 2 * s)) return i - s;
        return -1;
    endfunction

endpackage

// File: rtl/pfx_pg_gen.sv
// Bit-level generate/propagate stage.
// Forms per-bit propagate, and per-node generate/propagate for the tree;
// the carry-in is folded into the bit-0 generate so prefix carries include it.
module pfx_pg_gen #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             c_in,
    output logic [WIDTH-1:0] p_bit,
    output logic [WIDTH-1:0] g_node,
    output logic [WIDTH-1:0] p_node
);

    // Per-bit generate and propagate, carry-in merged into bit 0
    always_comb begin
        p_bit  = a_in ^ b_in;
        p_node = p_bit;
        g_node = a_in & b_in;
        g_node[0] = (a_in[0] & b_in[0]) | (p_bit[0] & c_in);
    end

endmodule

// File: rtl/pfx_combine.sv
// Two-input group cell: merges an upper span with the span directly below it.
// Assumes the two spans are adjacent, upper one on the hi inputs.
module pfx_combine (
    input  logic g_hi,
    input  logic p_hi,
    input  logic g_lo,
    input  logic p_lo,
    output logic g_out,
    output logic p_out
);

    // Group generate/propagate of the joined span
    always_comb begin
        g_out = g_hi | (p_hi & g_lo);
        p_out = p_hi & p_lo;
    end

endmodule

// File: rtl/pfx_tree.sv
// Prefix network: levels of group cells wired by the selected topology.
// Output node i holds generate/propagate of span [i:0]. Assumes WIDTH = 2**k, k >= 1.
module pfx_tree #(
    parameter int WIDTH    = 32,
    parameter int TOPOLOGY = 0
) (
    input  logic [WIDTH-1:0] g_node,
    input  logic [WIDTH-1:0] p_node,
    output logic [WIDTH-1:0] g_pre,
    output logic [WIDTH-1:0] p_pre
);
    import pfx_adder_pkg::*;

    localparam int LG    = $clog2(WIDTH);
    localparam int DEPTH = tree_depth(TOPOLOGY, LG);

    logic [DEPTH:0][WIDTH-1:0] gl;
    logic [DEPTH:0][WIDTH-1:0] pl;

    assign gl[0] = g_node;
    assign pl[0] = p_node;

    // One row of cells or pass-throughs per level, partner chosen by topology
    for (genvar lv = 0; lv < DEPTH; lv++) begin : g_lvl
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            localparam int J = pair_index(TOPOLOGY, LG, lv, i);
            if (J >= 0) begin : g_cell
                pfx_combine u_cell (
                    .g_hi (gl[lv][i]),
                    .p_hi (pl[lv][i]),
                    .g_lo (gl[lv][J]),
                    .p_lo (pl[lv][J]),
                    .g_out(gl[lv+1][i]),
                    .p_out(pl[lv+1][i])
                );
            end else begin : g_pass
                assign gl[lv+1][i] = gl[lv][i];
                assign pl[lv+1][i] = pl[lv][i];
            end
        end
    end

    assign g_pre = gl[DEPTH];
    assign p_pre = pl[DEPTH];

    // Full-span propagate must agree with the bit propagates fed into the tree
    always_comb begin
        if (!$isunknown(p_node) && !$isunknown(p_pre)) begin
            // R3
            span_prop_chk: assert (p_pre[WIDTH-1] == (&p_node))
                else $error("full-span propagate mismatch");
        end
    end

endmodule

// File: rtl/pfx_sum.sv
// Sum stage: XORs each bit propagate with the carry arriving at that bit.
// Assumes g_pre[i] already includes the carry-in.
module pfx_sum #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] p_bit,
    input  logic [WIDTH-1:0] g_pre,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             c_out
);

    // Carry into bit i is the prefix generate of bits below it
    always_comb begin
        sum_out = p_bit ^ {g_pre[WIDTH-2:0], c_in};
        c_out   = g_pre[WIDTH-1];
    end

endmodule

// File: rtl/pfx_tree_adder.sv
// Top: combinational parallel-prefix adder with selectable tree wiring.
// TOPOLOGY: 0 stride-doubling, 1 recursive split, 2 up/down sweep.
// Assumes WIDTH is a power of two between 2 and 63.
module pfx_tree_adder #(
    parameter int WIDTH    = 32,
    parameter int TOPOLOGY = 0
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             c_out,
    output logic [7:0]       tree_levels
);
    import pfx_adder_pkg::*;

    localparam int LG    = $clog2(WIDTH);
    localparam int DEPTH = tree_depth(TOPOLOGY, LG);

    logic [WIDTH-1:0] p_bit;
    logic [WIDTH-1:0] g_node;
    logic [WIDTH-1:0] p_node;
    logic [WIDTH-1:0] g_pre;
    logic [WIDTH-1:0] p_pre;

    pfx_pg_gen #(.WIDTH(WIDTH)) u_pg (
        .a_in  (a_in),
        .b_in  (b_in),
        .c_in  (c_in),
        .p_bit (p_bit),
        .g_node(g_node),
        .p_node(p_node)
    );

    pfx_tree #(.WIDTH(WIDTH), .TOPOLOGY(TOPOLOGY)) u_tree (
        .g_node(g_node),
        .p_node(p_node),
        .g_pre (g_pre),
        .p_pre (p_pre)
    );

    pfx_sum #(.WIDTH(WIDTH)) u_sum (
        .p_bit  (p_bit),
        .g_pre  (g_pre),
        .c_in   (c_in),
        .sum_out(sum_out),
        .c_out  (c_out)
    );

    // Constant report of the levels built
    assign tree_levels = 8'(DEPTH);

    // Whole-word result against a behavioural sum
    logic [WIDTH:0] ref_total;
    assign ref_total = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in};

    always_comb begin
        if (!$isunknown({a_in, b_in, c_in})) begin
            // R1
            sum_value_chk: assert (sum_out == ref_total[WIDTH-1:0])
                else $error("sum mismatch");
            // R2
            carry_out_chk: assert (c_out == ref_total[WIDTH])
                else $error("carry-out mismatch");
            // R3
            all_prop_chk: assert (!(&(a_in ^ b_in)) || (c_out == c_in))
                else $error("full propagate did not pass carry-in");
        end
    end

    // Per-node prefix carry against a masked behavioural sum
    for (genvar i = 0; i < WIDTH; i++) begin : g_node_chk
        localparam logic [WIDTH:0] MASK = ({{WIDTH{1'b0}}, 1'b1} << (i + 1)) - 1'b1;
        logic [WIDTH:0] part;
        assign part = ({1'b0, a_in} & MASK) + ({1'b0, b_in} & MASK) + {{WIDTH{1'b0}}, c_in};
        always_comb begin
            if (!$isunknown({a_in, b_in, c_in})) begin
                // R8
                node_carry_chk: assert (g_pre[i] == part[i+1])
                    else $error("prefix carry mismatch at node %0d", i);
            end
        end
    end

endmodule

// File: tb/pfx_tree_adder_tb.sv
module pfx_tree_adder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 3000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Narrow instances, one per topology
    logic [7:0]  a8, b8;
    logic        c8;
    logic [7:0]  s8  [3];
    logic        co8 [3];
    logic [7:0]  lv8 [3];

    // Wide instances, one per topology
    logic [31:0] a32, b32;
    logic        c32;
    logic [31:0] s32 [3];
    logic        co32[3];
    logic [7:0]  lv32[3];

    for (genvar t = 0; t < 3; t++) begin : g_n8
        pfx_tree_adder #(.WIDTH(8), .TOPOLOGY(t)) u_dut (
            .a_in(a8), .b_in(b8), .c_in(c8),
            .sum_out(s8[t]), .c_out(co8[t]), .tree_levels(lv8[t])
        );
    end

    for (genvar t = 0; t < 3; t++) begin : g_n32
        pfx_tree_adder #(.WIDTH(32), .TOPOLOGY(t)) u_dut (
            .a_in(a32), .b_in(b32), .c_in(c32),
            .sum_out(s32[t]), .c_out(co32[t]), .tree_levels(lv32[t])
        );
    end

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic        ci;
        logic [31:0] s;
        logic        co;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0},
        '{32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b1},
        '{32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1},
        '{32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 32'h0000_0000, 1'b1},
        '{32'h1234_5678, 32'h8765_4321, 1'b0, 32'h9999_9999, 1'b0},
        '{32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 32'h8000_0000, 1'b0},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b1},
        '{32'h0F0F_0F0F, 32'h0F0F_0F0F, 1'b1, 32'h1E1E_1E1F, 1'b0}
    };

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [32:0] exp33;
        a8 = '0; b8 = '0; c8 = 1'b0;
        a32 = '0; b32 = '0; c32 = 1'b0;
        #3;

        // Idle state: zero operands give zero result
        for (int t = 0; t < 3; t++) chk("R1 zero", {55'd0, co8[t], s8[t]}, 64'd0);

        // R4 R5 R6: structural level counts
        chk("R4 stride N8",  {56'd0, lv8[0]},  64'd3);
        chk("R5 split N8",   {56'd0, lv8[1]},  64'd3);
        chk("R6 sparse N8",  {56'd0, lv8[2]},  64'd5);
        chk("R4 stride N32", {56'd0, lv32[0]}, 64'd5);
        chk("R5 split N32",  {56'd0, lv32[1]}, 64'd5);
        chk("R6 sparse N32", {56'd0, lv32[2]}, 64'd9);

        // R1 R2: vector table walked for every topology
        for (int v = 0; v < NV; v++) begin
            a32 = VECS[v].a; b32 = VECS[v].b; c32 = VECS[v].ci;
            #1;
            for (int t = 0; t < 3; t++) begin
                chk("R1 table sum",   {32'd0, s32[t]}, {32'd0, VECS[v].s});
                chk("R2 table carry", {63'd0, co32[t]}, {63'd0, VECS[v].co});
            end
        end

        // R3: all-propagate operands, both carry-in values
        a32 = 32'hC3A5_0FF0; b32 = ~32'hC3A5_0FF0; c32 = 1'b1;
        #1;
        for (int t = 0; t < 3; t++) chk("R3 cin1", {31'd0, co32[t], s32[t]}, {31'd0, 1'b1, 32'd0});
        c32 = 1'b0;
        #1;
        for (int t = 0; t < 3; t++) chk("R3 cin0", {31'd0, co32[t], s32[t]}, {31'd0, 1'b0, 32'hFFFF_FFFF});

        // R8: outputs follow a new input within the same time step, no clock edge
        @(negedge clk);
        a32 = 32'h0000_FFFF; b32 = 32'h0000_0001; c32 = 1'b0;
        #1;
        for (int t = 0; t < 3; t++) chk("R8 no clock", {31'd0, co32[t], s32[t]}, 64'h1_0000);

        // R1 R2: random wide vectors
        for (int k = 0; k < N_RAND; k++) begin
            a32 = $urandom; b32 = $urandom; c32 = 1'($urandom);
            #1;
            exp33 = {1'b0, a32} + {1'b0, b32} + {32'd0, c32};
            for (int t = 0; t < 3; t++) begin
                chk("R1 random sum",   {32'd0, s32[t]}, {32'd0, exp33[31:0]});
                chk("R2 random carry", {63'd0, co32[t]}, {63'd0, exp33[32]});
            end
        end

        // R7: exhaustive narrow width for every topology
        for (int ai = 0; ai < 256; ai++) begin
            for (int bi = 0; bi < 256; bi++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    a8 = ai[7:0]; b8 = bi[7:0]; c8 = ci[0];
                    #1;
                    for (int t = 0; t < 3; t++)
                        chk("R7 exhaustive", {55'd0, co8[t], s8[t]}, 64'(ai + bi + ci));
                end
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule